// File: doc/BRIEF.md
# Phased SPI Master Sequencer

This block drives one SPI master transaction as a fixed chain of up to five optional phases: an opcode phase, an address phase, a run of dummy clocks, a write-data phase and a read-data phase. Each phase has its own enable bit and its own length field, which holds the bit count minus one. A single data word serves both data phases: the write phase shifts it out and the read phase shifts received bits into it. Each direction picks its own bit order. In the first order the whole word runs from its top bit down. In the second the bytes run from the lowest up, and each byte still goes top bit first.

The host first loads the data word while the engine is idle. It then sets the enables, lengths, opcode image, address and options, and pulses `start`. The engine copies the whole configuration, lowers chip select, and raises `busy` until the last phase and the optional hold period are over. It then releases chip select and pulses `done` for one cycle. Bit timing comes from an external divider through the `tick` strobe. Each tick advances SCLK by half a period. SCLK idles low. MOSI changes only while SCLK is low, and MISO is sampled on the rising edge.

Top module: `spi_seq_engine`

## Requirements
- R1: Enabled phases run in the order opcode, address, dummy, write, read, and disabled phases are skipped. `ph_en` bit 0 enables opcode, bit 1 address, bit 2 dummy, bit 3 write and bit 4 read. Each enabled phase gives exactly its length field plus one rising SCLK edges.
- R2: The opcode image holds the opcode left-aligned with its two bytes swapped. The bits sent are `{cmd_img[7:0], cmd_img[15:8]}`, starting from its bit 15.
- R3: The address phase sends `addr_word` from bit 31 downward, so a shorter address must be left-aligned.
- R4: With `tx_msb_word`=1 the write phase sends the data word from bit 31 downward.
- R5: With `tx_msb_word`=0 the write bit with index i (counted from 0) comes from word bit 8*(i/8)+7-(i%8). Byte 0 goes first, and each byte starts at its top bit.
- R6: The read phase writes MISO bit i into word bit 31-i when `rx_msb_word`=1, and into bit 8*(i/8)+7-(i%8) when it is 0. Word bits that no received bit covers keep their value.
- R7: During dummy clocks SCLK toggles, MOSI stays 0 and MISO is not captured.
- R8: `busy` rises in the cycle after an accepted `start`. A `start` seen while busy is ignored, and the configuration copied at launch stays in force.
- R9: `cs_n` stays low for the whole transaction and SCLK is high only while `cs_n` is low. With `tick` high every cycle, `cs_n` is low for 2·(total bits) + `cs_setup` + `cs_hold` cycles.
- R10: `done` is a one-cycle pulse in the first cycle with `busy` low after a transaction.
- R11: `buf_load` writes `buf_wdata` into the word only while idle. While busy it has no effect.
- R12: SCLK changes only on a `tick` cycle. MOSI is stable while SCLK is high, and SCLK is low when idle.
- R13: After reset `busy`, `done` and `sclk` are 0, `cs_n` is 1 and the data word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Half-period strobe from the clock divider |
| start | input | 1 | Launch pulse, taken only when idle |
| ph_en | input | 5 | Phase enables: bit0 opcode, bit1 address, bit2 dummy, bit3 write, bit4 read |
| cmd_len | input | 4 | Opcode bits minus one |
| cmd_img | input | 16 | Opcode register image, left-aligned, bytes swapped |
| addr_len | input | 5 | Address bits minus one |
| addr_word | input | 32 | Address, left-aligned |
| dummy_len | input | 8 | Dummy clocks minus one |
| wr_len | input | 5 | Write bits minus one |
| rd_len | input | 5 | Read bits minus one |
| tx_msb_word | input | 1 | Write order: 1 whole word top-down, 0 lowest byte first |
| rx_msb_word | input | 1 | Read order: 1 whole word top-down, 0 lowest byte first |
| cs_setup | input | 1 | Adds one tick between chip select falling and the first SCLK edge |
| cs_hold | input | 1 | Adds one tick between the last SCLK edge and chip select rising |
| buf_load | input | 1 | Writes the data word (idle only) |
| buf_wdata | input | 32 | Value for the data word |
| buf_word | output | 32 | Current data word |
| sclk | output | 1 | SPI clock, idles low |
| mosi | output | 1 | Master data out |
| miso | input | 1 | Master data in |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
The assertions assume that `tick` comes from a free-running divider and keeps arriving. They also assume that each length field fits its phase, so the opcode never exceeds 16 bits and a data phase never exceeds the word. MISO is expected to hold steady around each rising SCLK edge. The stimulus keeps to these limits. It changes MISO only after a falling SCLK edge, drives every input at the falling core-clock edge, and uses divider ratios of one, two and three cycles.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    localparam int NUM_PH = 5;

    typedef enum logic [2:0] {
        PH_CMD   = 3'd0,
        PH_ADDR  = 3'd1,
        PH_DUMMY = 3'd2,
        PH_WR    = 3'd3,
        PH_RD    = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD
    } state_e;

    // Lowest enabled phase at or after 'from': {found, phase}.
    function automatic logic [3:0] first_phase(logic [NUM_PH-1:0] en, int from);
        logic [3:0] r;
        r = '0;
        for (int k = NUM_PH - 1; k >= 0; k--) begin
            if (k >= from && en[k]) r = {1'b1, 3'(k)};
        end
        return r;
    endfunction

    // Word bit touched by serial bit i, for either ordering.
    function automatic int word_slot(logic msb_first, int i, int width);
        if (msb_first) return width - 1 - i;
        return (i / 8) * 8 + 7 - (i % 8);
    endfunction

endpackage

// File: rtl/spi_seq_txbit.sv
module spi_seq_txbit
    import spi_seq_pkg::*;
#(
    parameter int CMD_W  = 16,
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              active,
    input  phase_e            phase,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CMD_W-1:0]  cmd_img,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] word,
    input  logic              tx_msb,
    output logic              mosi
);
    localparam int CMD_LW  = $clog2(CMD_W);
    localparam int ADDR_LW = $clog2(ADDR_W);
    localparam int WORD_LW = $clog2(WORD_W);
    localparam int HALF    = CMD_W / 2;

    logic [CMD_W-1:0]   cmd_lin;
    logic [CMD_LW-1:0]  cmd_idx;
    logic [ADDR_LW-1:0] addr_idx;
    logic [WORD_LW-1:0] word_idx;

    always_comb begin
        cmd_lin  = {cmd_img[HALF-1:0], cmd_img[CMD_W-1:HALF]};
        cmd_idx  = CMD_LW'(CMD_W - 1 - int'(cnt));
        addr_idx = ADDR_LW'(ADDR_W - 1 - int'(cnt));
        word_idx = WORD_LW'(word_slot(tx_msb, int'(cnt), WORD_W));
        mosi     = 1'b0;
        if (active) begin
            case (phase)
                PH_CMD:  mosi = cmd_lin[cmd_idx];
                PH_ADDR: mosi = addr[addr_idx];
                PH_WR:   mosi = word[word_idx];
                default: mosi = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/spi_seq_wordbuf.sv
module spi_seq_wordbuf
    import spi_seq_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              load,
    input  logic [WORD_W-1:0] wdata,
    input  logic              cap,
    input  logic [CNT_W-1:0]  cap_cnt,
    input  logic              rx_msb,
    input  logic              cap_bit,
    output logic [WORD_W-1:0] word
);
    localparam int WORD_LW = $clog2(WORD_W);

    logic [WORD_W-1:0]  word_d, word_q;
    logic [WORD_LW-1:0] slot;

    always_comb begin
        slot   = WORD_LW'(word_slot(rx_msb, int'(cap_cnt), WORD_W));
        word_d = word_q;
        if (idle && load) begin
            word_d = wdata;
        end else if (cap) begin
            word_d[slot] = cap_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word = word_q;

    // R11
    load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && load && !cap) |=> $stable(word_q));

    // R6
    cap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> !idle);
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
    import spi_seq_pkg::*;
#(
    parameter int CMD_W    = 16,
    parameter int ADDR_W   = 32,
    parameter int WORD_W   = 32,
    parameter int DUMMY_LW = 8,
    localparam int CMD_LW  = $clog2(CMD_W),
    localparam int ADDR_LW = $clog2(ADDR_W),
    localparam int WORD_LW = $clog2(WORD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               start,
    input  logic [NUM_PH-1:0]  ph_en,
    input  logic [CMD_LW-1:0]  cmd_len,
    input  logic [CMD_W-1:0]   cmd_img,
    input  logic [ADDR_LW-1:0] addr_len,
    input  logic [ADDR_W-1:0]  addr_word,
    input  logic [DUMMY_LW-1:0] dummy_len,
    input  logic [WORD_LW-1:0] wr_len,
    input  logic [WORD_LW-1:0] rd_len,
    input  logic               tx_msb_word,
    input  logic               rx_msb_word,
    input  logic               cs_setup,
    input  logic               cs_hold,
    input  logic               buf_load,
    input  logic [WORD_W-1:0]  buf_wdata,
    output logic [WORD_W-1:0]  buf_word,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic               cs_n,
    output logic               busy,
    output logic               done
);
    localparam int LW_A  = (CMD_LW > ADDR_LW) ? CMD_LW : ADDR_LW;
    localparam int LW_B  = (WORD_LW > DUMMY_LW) ? WORD_LW : DUMMY_LW;
    localparam int CNT_W = (LW_A > LW_B) ? LW_A : LW_B;

    typedef struct packed {
        logic [NUM_PH-1:0]   en;
        logic [CMD_LW-1:0]   cmd_len;
        logic [CMD_W-1:0]    cmd_img;
        logic [ADDR_LW-1:0]  addr_len;
        logic [ADDR_W-1:0]   addr;
        logic [DUMMY_LW-1:0] dummy_len;
        logic [WORD_LW-1:0]  wr_len;
        logic [WORD_LW-1:0]  rd_len;
        logic                tx_msb;
        logic                rx_msb;
        logic                setup;
        logic                hold;
    } cfg_t;

    typedef struct packed {
        state_e           state;
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             sclk;
        logic             cs_n;
        logic             busy;
        logic             done;
        cfg_t             cfg;
    } regs_t;

    regs_t            d, q;
    logic [CNT_W-1:0] last;
    logic [3:0]       nxt;
    logic             cap;

    always_comb begin
        case (q.phase)
            PH_CMD:   last = CNT_W'(q.cfg.cmd_len);
            PH_ADDR:  last = CNT_W'(q.cfg.addr_len);
            PH_DUMMY: last = CNT_W'(q.cfg.dummy_len);
            PH_WR:    last = CNT_W'(q.cfg.wr_len);
            default:  last = CNT_W'(q.cfg.rd_len);
        endcase

        d      = q;
        d.done = 1'b0;
        cap    = 1'b0;
        nxt    = '0;

        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.cfg.en        = ph_en;
                    d.cfg.cmd_len   = cmd_len;
                    d.cfg.cmd_img   = cmd_img;
                    d.cfg.addr_len  = addr_len;
                    d.cfg.addr      = addr_word;
                    d.cfg.dummy_len = dummy_len;
                    d.cfg.wr_len    = wr_len;
                    d.cfg.rd_len    = rd_len;
                    d.cfg.tx_msb    = tx_msb_word;
                    d.cfg.rx_msb    = rx_msb_word;
                    d.cfg.setup     = cs_setup;
                    d.cfg.hold      = cs_hold;
                    nxt     = first_phase(ph_en, 0);
                    d.phase = phase_e'(nxt[2:0]);
                    d.cnt   = '0;
                    d.sclk  = 1'b0;
                    d.busy  = 1'b1;
                    d.cs_n  = 1'b0;
                    if (cs_setup)    d.state = ST_SETUP;
                    else if (nxt[3]) d.state = ST_SHIFT;
                    else             d.state = ST_HOLD;
                end
            end
            ST_SETUP: begin
                if (tick) d.state = (q.cfg.en != '0) ? ST_SHIFT : ST_HOLD;
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk = 1'b1;
                        cap    = (q.phase == PH_RD);
                    end else begin
                        d.sclk = 1'b0;
                        if (q.cnt == last) begin
                            d.cnt = '0;
                            nxt   = first_phase(q.cfg.en, int'(q.phase) + 1);
                            if (nxt[3]) begin
                                d.phase = phase_e'(nxt[2:0]);
                            end else if (q.cfg.hold) begin
                                d.state = ST_HOLD;
                            end else begin
                                d.state = ST_IDLE;
                                d.busy  = 1'b0;
                                d.cs_n  = 1'b1;
                                d.done  = 1'b1;
                            end
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    d.state = ST_IDLE;
                    d.busy  = 1'b0;
                    d.cs_n  = 1'b1;
                    d.done  = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk = q.sclk;
    assign cs_n = q.cs_n;
    assign busy = q.busy;
    assign done = q.done;

    spi_seq_txbit #(
        .CMD_W (CMD_W),
        .ADDR_W(ADDR_W),
        .WORD_W(WORD_W),
        .CNT_W (CNT_W)
    ) u_txbit (
        .active (q.state == ST_SHIFT),
        .phase  (q.phase),
        .cnt    (q.cnt),
        .cmd_img(q.cfg.cmd_img),
        .addr   (q.cfg.addr),
        .word   (buf_word),
        .tx_msb (q.cfg.tx_msb),
        .mosi   (mosi)
    );

    spi_seq_wordbuf #(
        .WORD_W(WORD_W),
        .CNT_W (CNT_W)
    ) u_wordbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .idle   (!q.busy),
        .load   (buf_load),
        .wdata  (buf_wdata),
        .cap    (cap),
        .cap_cnt(q.cnt),
        .rx_msb (q.cfg.rx_msb),
        .cap_bit(miso),
        .word   (buf_word)
    );

    // R12
    sclk_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(q.sclk));

    // R12
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sclk && $past(q.sclk)) |-> $stable(mosi));

    // R9
    cs_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.sclk |-> !q.cs_n);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R10
    done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (!q.busy && $past(q.busy)));

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && start) |=> $stable(q.cfg));

    // R1
    phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $past(q.busy)) |-> (q.phase >= $past(q.phase)));
endmodule

// File: tb/spi_seq_engine_tb.sv
module spi_seq_engine_tb;
    import spi_seq_pkg::*;

    typedef struct packed {
        logic [4:0]  en;
        logic [3:0]  clen;
        logic [15:0] cimg;
        logic [4:0]  alen;
        logic [31:0] aw;
        logic [7:0]  dlen;
        logic [4:0]  wlen;
        logic [4:0]  rlen;
        logic        txm;
        logic        rxm;
        logic        setup;
        logic        hold;
        logic [31:0] wdata;
        logic [31:0] rpat;
        logic [1:0]  div;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{5'b00001, 4'd7,  16'h00A5, 5'd0,  32'h0,        8'd0, 5'd0,  5'd0,  1'b1, 1'b1, 1'b0, 1'b0, 32'h0,        32'h0,        2'd1},
        '{5'b00011, 4'd15, 16'h3412, 5'd23, 32'hABCDEF00, 8'd0, 5'd0,  5'd0,  1'b1, 1'b1, 1'b0, 1'b0, 32'h0,        32'h0,        2'd2},
        '{5'b01000, 4'd0,  16'h0,    5'd0,  32'h0,        8'd0, 5'd31, 5'd0,  1'b1, 1'b1, 1'b0, 1'b0, 32'hDEADBEEF, 32'h0,        2'd1},
        '{5'b01000, 4'd0,  16'h0,    5'd0,  32'h0,        8'd0, 5'd31, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 32'h12345678, 32'h0,        2'd3},
        '{5'b01000, 4'd0,  16'h0,    5'd0,  32'h0,        8'd0, 5'd11, 5'd0,  1'b0, 1'b1, 1'b0, 1'b1, 32'h0000FDA4, 32'h0,        2'd1},
        '{5'b10000, 4'd0,  16'h0,    5'd0,  32'h0,        8'd0, 5'd0,  5'd31, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,        32'hCAFEF00D, 2'd1},
        '{5'b10000, 4'd0,  16'h0,    5'd0,  32'h0,        8'd0, 5'd0,  5'd15, 1'b1, 1'b0, 1'b0, 1'b0, 32'h55550000, 32'hA1B2C3D4, 2'd2},
        '{5'b11111, 4'd7,  16'h00C3, 5'd7,  32'h5A000000, 8'd3, 5'd7,  5'd7,  1'b1, 1'b1, 1'b1, 1'b1, 32'h9C0000F1, 32'h6E000000, 2'd1},
        '{5'b01100, 4'd0,  16'h0,    5'd0,  32'h0,        8'd5, 5'd3,  5'd0,  1'b1, 1'b1, 1'b0, 1'b0, 32'h0F0F0F0F, 32'hFFFFFFFF, 2'd1},
        '{5'b10100, 4'd0,  16'h0,    5'd0,  32'h0,        8'd2, 5'd0,  5'd7,  1'b1, 1'b0, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h3C000000, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  ph_en = '0;
    logic [3:0]  cmd_len = '0;
    logic [15:0] cmd_img = '0;
    logic [4:0]  addr_len = '0;
    logic [31:0] addr_word = '0;
    logic [7:0]  dummy_len = '0;
    logic [4:0]  wr_len = '0;
    logic [4:0]  rd_len = '0;
    logic        tx_msb_word = 1'b1;
    logic        rx_msb_word = 1'b1;
    logic        cs_setup = 1'b0;
    logic        cs_hold = 1'b0;
    logic        buf_load = 1'b0;
    logic [31:0] buf_wdata = '0;
    logic [31:0] buf_word;
    logic        sclk, mosi, miso, cs_n, busy, done;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int div_cfg = 1;
    int tcnt = 0;
    int rise_cnt = 0;
    int fall_cnt = 0;
    int cs_low = 0;
    int done_cnt = 0;
    int mosi_viol = 0;
    int fall_base = 0;
    int rd_start = 0;
    logic [31:0] cur_rpat = '0;
    logic prev_sclk = 1'b0;
    logic prev_mosi = 1'b0;
    logic rec [0:1023];
    logic exp_bits [0:255];
    logic [31:0] exp_buf;

    always #5 clk = ~clk;

    spi_seq_engine u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .ph_en(ph_en),
        .cmd_len(cmd_len), .cmd_img(cmd_img), .addr_len(addr_len),
        .addr_word(addr_word), .dummy_len(dummy_len), .wr_len(wr_len),
        .rd_len(rd_len), .tx_msb_word(tx_msb_word), .rx_msb_word(rx_msb_word),
        .cs_setup(cs_setup), .cs_hold(cs_hold), .buf_load(buf_load),
        .buf_wdata(buf_wdata), .buf_word(buf_word), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .busy(busy), .done(done)
    );

    // divider model, watchdog and monitors sampled at the falling clock edge
    always @(negedge clk) begin
        cyc++;
        if (tcnt + 1 >= div_cfg) begin tick = 1'b1; tcnt = 0; end
        else begin tick = 1'b0; tcnt++; end
        if (!cs_n) cs_low++;
        if (done) done_cnt++;
        if (sclk && prev_sclk && (mosi !== prev_mosi)) mosi_viol++;
        prev_sclk = sclk;
        prev_mosi = mosi;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog expired act=%0d exp=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    always @(posedge sclk) begin
        rec[rise_cnt % 1024] = mosi;
        rise_cnt++;
    end

    always @(negedge sclk) fall_cnt++;

    always_comb begin
        int k;
        k = fall_cnt - fall_base - rd_start;
        if (k >= 0 && k < 32) miso = cur_rpat[31 - k];
        else                  miso = 1'b1;
    end

    task automatic check(input bit ok, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    function automatic int slot(logic msb, int i);
        if (msb) return 31 - i;
        return (i / 8) * 8 + 7 - (i % 8);
    endfunction

    // expected serial stream and final word, from the requirements
    task automatic build_expect(input vec_t v, output int n);
        logic [15:0] c;
        n = 0;
        c = {v.cimg[7:0], v.cimg[15:8]};
        if (v.en[0]) for (int i = 0; i <= int'(v.clen); i++) begin exp_bits[n] = c[15 - i];  n++; end
        if (v.en[1]) for (int i = 0; i <= int'(v.alen); i++) begin exp_bits[n] = v.aw[31 - i]; n++; end
        if (v.en[2]) for (int i = 0; i <= int'(v.dlen); i++) begin exp_bits[n] = 1'b0; n++; end
        if (v.en[3]) for (int i = 0; i <= int'(v.wlen); i++) begin
            exp_bits[n] = v.wdata[slot(v.txm, i)]; n++;
        end
        rd_start = n;
        exp_buf = v.wdata;
        if (v.en[4]) for (int i = 0; i <= int'(v.rlen); i++) begin
            exp_bits[n] = 1'b0; n++;
            exp_buf[slot(v.rxm, i)] = v.rpat[31 - i];
        end
    endtask

    task automatic run_vec(input vec_t v, input int poke, input string tag);
        int n, rb, cb, db, vb, guard, bad;
        @(negedge clk);
        div_cfg = int'(v.div);
        ph_en = v.en; cmd_len = v.clen; cmd_img = v.cimg; addr_len = v.alen;
        addr_word = v.aw; dummy_len = v.dlen; wr_len = v.wlen; rd_len = v.rlen;
        tx_msb_word = v.txm; rx_msb_word = v.rxm; cs_setup = v.setup; cs_hold = v.hold;
        buf_wdata = v.wdata; buf_load = 1'b1;
        @(negedge clk);
        buf_load = 1'b0;
        check(buf_word == v.wdata, {tag, " R11 idle load"}, buf_word, v.wdata);
        cur_rpat = v.rpat;
        build_expect(v, n);
        fall_base = fall_cnt;
        rb = rise_cnt; cb = cs_low; db = done_cnt; vb = mosi_viol;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, {tag, " R8 busy after start"}, busy, 1);
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (poke == 1 && guard == 10) begin wr_len = 5'd3; start = 1'b1; end
            if (poke == 2 && guard == 10) begin buf_wdata = 32'h0; buf_load = 1'b1; end
            if (guard == 11) begin start = 1'b0; buf_load = 1'b0; end
        end
        check(done == 1'b1, {tag, " R10 done seen"}, done, 1);
        check(rise_cnt - rb == n, {tag, " R1 sclk rising edges"}, rise_cnt - rb, n);
        bad = 0;
        for (int k = 0; k < n; k++) if (rec[(rb + k) % 1024] !== exp_bits[k]) bad++;
        check(bad == 0, {tag, " R2 R3 R4 R5 R7 mosi stream bit errors"}, bad, 0);
        check(buf_word == exp_buf, {tag, " R6 word after transaction"}, buf_word, exp_buf);
        if (v.div == 2'd1)
            check(cs_low - cb == 2 * n + int'(v.setup) + int'(v.hold),
                  {tag, " R9 cs_n low cycles"}, cs_low - cb,
                  2 * n + int'(v.setup) + int'(v.hold));
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, {tag, " R10 done single cycle"},
              {done, busy}, 0);
        check(done_cnt - db == 1, {tag, " R10 done pulse count"}, done_cnt - db, 1);
        check(sclk == 1'b0 && cs_n == 1'b1 && mosi_viol == vb,
              {tag, " R12 idle sclk and mosi held while high"},
              {sclk, cs_n, 8'(mosi_viol - vb)}, 2'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && sclk == 0 && cs_n == 1,
              "R13 outputs in reset", {busy, done, sclk, cs_n}, 4'b0001);
        rst_n = 1'b1;
        @(negedge clk);
        check(buf_word == 32'h0, "R13 word after reset", buf_word, 0);
        check(busy == 0 && cs_n == 1, "R13 idle after reset", {busy, cs_n}, 2'b01);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 0, $sformatf("vec%0d", i));

        // R8: second start while busy, with a shorter length on the inputs
        run_vec(VECS[2], 1, "start_while_busy R8");
        // R11: load while busy leaves the word and the stream untouched
        run_vec(VECS[3], 2, "load_while_busy R11");
        check(buf_word == VECS[3].wdata, "R11 word kept after busy load",
              buf_word, VECS[3].wdata);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule